// File: doc/BRIEF.md
# Dynamic Cache Refresh Sequencer

This block keeps a dynamic-cell cache sub-array alive by sweeping it periodically. A free-running retention timer, loaded with the array's retention period in clock cycles, raises a request each time the period elapses. The request starts a sweep that walks every chunk of every line. Each chunk is read through an existing array read port, and the returned data is written back through an existing write port one cycle later. The tag entry of a line is read and rewritten together with the first chunk of that line.

The sweep borrows normal ports, so the block raises a hold output for the whole sweep. The load/store scheduler uses it to delay ordinary accesses. A request that arrives while a sweep is running is remembered. The next sweep then follows without a gap. The array itself returns read data one cycle after a read enable, and that data is written back unchanged.

Top module: `dyn_refresh_seq`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, hold_o, rd_en_o, wr_en_o, tag_rd_en_o and tag_wr_en_o are all 0.
- R2: With a nonzero period_i held at value P, the retention timer requests a sweep every P cycles. An idle sequencer raises hold_o in the cycle after the request.
- R3: A period_i of 0 stops the timer, and no new sweep ever starts while it stays 0.
- R4: If period_i is lowered to a value at or below the current timer count, a request fires at the next clock edge.
- R5: hold_o rises one cycle before the first refresh read of a sweep. It falls in the cycle after the last write-back of that sweep.
- R6: Within a sweep, reads run on consecutive cycles in line-major order: rd_chunk_o counts 0 to CHUNKS-1 within a line, then rd_line_o increases from 0 to LINES-1. Each sweep makes exactly LINES*CHUNKS reads.
- R7: Every read is followed in the next cycle by a write (wr_en_o) to the same line and chunk. wr_data_o equals rd_data_i in that cycle.
- R8: tag_rd_en_o is asserted only with the read of chunk 0 of a line. tag_wr_en_o is asserted with that chunk's write-back, and wr_tag_o equals rd_tag_i in that cycle.
- R9: A request that arrives while a sweep is active, including in its final write cycle, starts the next sweep in the cycle right after the current one ends. hold_o stays high between the two sweeps.
- R10: Any number of requests during one sweep produce only one follow-on sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | PERIOD_W | Retention period in cycles; 0 disables the timer |
| rd_data_i | input | CHUNK_W | Chunk data returned by the array, one cycle after rd_en_o |
| rd_tag_i | input | TAG_W | Tag returned by the array, one cycle after tag_rd_en_o |
| hold_o | output | 1 | Port hold to the scheduler during a sweep |
| rd_en_o | output | 1 | Refresh read on the borrowed read port |
| rd_line_o | output | clog2(LINES) | Line index of the refresh read |
| rd_chunk_o | output | clog2(CHUNKS) | Chunk index of the refresh read |
| tag_rd_en_o | output | 1 | Tag read for the line being read |
| wr_en_o | output | 1 | Refresh write on the borrowed write port |
| wr_line_o | output | clog2(LINES) | Line index of the write-back |
| wr_chunk_o | output | clog2(CHUNKS) | Chunk index of the write-back |
| wr_data_o | output | CHUNK_W | Data written back |
| tag_wr_en_o | output | 1 | Tag write-back |
| wr_tag_o | output | TAG_W | Tag written back |

## Verification
A timer request and the last write-back of a sweep can occur in the same cycle. So can a request and a sweep that is still running. Either case must turn into a single queued follow-on sweep, with no gap in hold_o. The bench provokes both by setting periods shorter than one sweep, and it varies random periods so that requests land at arbitrary points, sweep ends among them. A cycle-level model built from the requirements predicts hold_o and every port action. The bench also counts the arming cycles of the sweeps to confirm that several requests during one sweep give exactly one extra sweep.

// File: rtl/dyn_refresh_pkg.sv
package dyn_refresh_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARM   = 2'd1,
    SEQ_RUN   = 2'd2,
    SEQ_DRAIN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rfr_timer.sv
module rfr_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                expire_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic                active;

  assign active   = (period_i != '0);
  // >= so a shortened period fires at once instead of wrapping
  assign expire_o = active && (cnt_q >= period_i - PERIOD_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!active || expire_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + PERIOD_W'(1);
  end
endmodule

// File: rtl/rfr_addr_gen.sv
module rfr_addr_gen #(
  parameter int LINES    = 256,
  parameter int CHUNKS   = 8,
  parameter int LINE_AW  = (LINES > 1) ? $clog2(LINES) : 1,
  parameter int CHUNK_AW = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                step_i,
  output logic [LINE_AW-1:0]  line_o,
  output logic [CHUNK_AW-1:0] chunk_o,
  output logic                last_o
);
  logic [LINE_AW-1:0] line_q;
  logic               chunk_last;
  logic               line_last;

  assign line_last = (line_q == LINE_AW'(LINES - 1));

  generate
    if (CHUNKS > 1) begin : g_chunk_cnt
      logic [CHUNK_AW-1:0] chunk_q;
      assign chunk_last = (chunk_q == CHUNK_AW'(CHUNKS - 1));
      assign chunk_o    = chunk_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   chunk_q <= '0;
        else if (clear_i)              chunk_q <= '0;
        else if (step_i && chunk_last) chunk_q <= '0;
        else if (step_i)               chunk_q <= chunk_q + CHUNK_AW'(1);
      end
    end else begin : g_chunk_none
      assign chunk_last = 1'b1;
      assign chunk_o    = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   line_q <= '0;
    else if (clear_i)              line_q <= '0;
    else if (step_i && chunk_last) line_q <= line_last ? '0 : line_q + LINE_AW'(1);
  end

  assign line_o = line_q;
  assign last_o = line_last && chunk_last;
endmodule

// File: rtl/rfr_wb_stage.sv
module rfr_wb_stage #(
  parameter int LINE_AW  = 8,
  parameter int CHUNK_AW = 3,
  parameter int CHUNK_W  = 64,
  parameter int TAG_W    = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_en_i,
  input  logic                tag_rd_en_i,
  input  logic [LINE_AW-1:0]  rd_line_i,
  input  logic [CHUNK_AW-1:0] rd_chunk_i,
  input  logic [CHUNK_W-1:0]  rd_data_i,
  input  logic [TAG_W-1:0]    rd_tag_i,
  output logic                wr_en_o,
  output logic                tag_wr_en_o,
  output logic [LINE_AW-1:0]  wr_line_o,
  output logic [CHUNK_AW-1:0] wr_chunk_o,
  output logic [CHUNK_W-1:0]  wr_data_o,
  output logic [TAG_W-1:0]    wr_tag_o
);
  logic                vld_q;
  logic                tag_q;
  logic [LINE_AW-1:0]  line_q;
  logic [CHUNK_AW-1:0] chunk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      tag_q   <= 1'b0;
      line_q  <= '0;
      chunk_q <= '0;
    end else begin
      vld_q   <= rd_en_i;
      tag_q   <= tag_rd_en_i;
      line_q  <= rd_line_i;
      chunk_q <= rd_chunk_i;
    end
  end

  // array data arrives in the write cycle; forwarded without a register
  assign wr_en_o     = vld_q;
  assign tag_wr_en_o = tag_q;
  assign wr_line_o   = line_q;
  assign wr_chunk_o  = chunk_q;
  assign wr_data_o   = vld_q ? rd_data_i : '0;
  assign wr_tag_o    = tag_q ? rd_tag_i  : '0;
endmodule

// File: rtl/dyn_refresh_seq.sv
module dyn_refresh_seq
  import dyn_refresh_pkg::*;
#(
  parameter int LINES    = 256,
  parameter int CHUNKS   = 8,
  parameter int CHUNK_W  = 64,
  parameter int TAG_W    = 20,
  parameter int PERIOD_W = 16,
  localparam int LINE_AW  = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int CHUNK_AW = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [CHUNK_W-1:0]  rd_data_i,
  input  logic [TAG_W-1:0]    rd_tag_i,
  output logic                hold_o,
  output logic                rd_en_o,
  output logic [LINE_AW-1:0]  rd_line_o,
  output logic [CHUNK_AW-1:0] rd_chunk_o,
  output logic                tag_rd_en_o,
  output logic                wr_en_o,
  output logic [LINE_AW-1:0]  wr_line_o,
  output logic [CHUNK_AW-1:0] wr_chunk_o,
  output logic [CHUNK_W-1:0]  wr_data_o,
  output logic                tag_wr_en_o,
  output logic [TAG_W-1:0]    wr_tag_o
);
  seq_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       expire;
  logic       sweep_last;
  logic       accept;

  rfr_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .expire_o (expire)
  );

  rfr_addr_gen #(
    .LINES   (LINES),
    .CHUNKS  (CHUNKS),
    .LINE_AW (LINE_AW),
    .CHUNK_AW(CHUNK_AW)
  ) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state_q == SEQ_ARM),
    .step_i  (rd_en_o),
    .line_o  (rd_line_o),
    .chunk_o (rd_chunk_o),
    .last_o  (sweep_last)
  );

  // idle or final write cycle: a new sweep may be taken
  assign accept = (state_q == SEQ_IDLE) || (state_q == SEQ_DRAIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (expire) state_d = SEQ_ARM;
      SEQ_ARM:   state_d = SEQ_RUN;
      SEQ_RUN:   if (sweep_last) state_d = SEQ_DRAIN;
      SEQ_DRAIN: state_d = (pend_q || expire) ? SEQ_ARM : SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  // single-entry request queue; extra requests merge
  assign pend_d = accept ? 1'b0 : (pend_q || expire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign hold_o      = (state_q != SEQ_IDLE);
  assign rd_en_o     = (state_q == SEQ_RUN);
  assign tag_rd_en_o = rd_en_o && (rd_chunk_o == '0);

  rfr_wb_stage #(
    .LINE_AW (LINE_AW),
    .CHUNK_AW(CHUNK_AW),
    .CHUNK_W (CHUNK_W),
    .TAG_W   (TAG_W)
  ) u_wb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en_o),
    .tag_rd_en_i (tag_rd_en_o),
    .rd_line_i   (rd_line_o),
    .rd_chunk_i  (rd_chunk_o),
    .rd_data_i   (rd_data_i),
    .rd_tag_i    (rd_tag_i),
    .wr_en_o     (wr_en_o),
    .tag_wr_en_o (tag_wr_en_o),
    .wr_line_o   (wr_line_o),
    .wr_chunk_o  (wr_chunk_o),
    .wr_data_o   (wr_data_o),
    .wr_tag_o    (wr_tag_o)
  );
endmodule

// File: rtl/dyn_refresh_seq_chk.sv
module dyn_refresh_seq_chk #(
  parameter int LINES    = 256,
  parameter int CHUNKS   = 8,
  parameter int PERIOD_W = 16,
  parameter int LINE_AW  = 8,
  parameter int CHUNK_AW = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [PERIOD_W-1:0] period_i,
  input logic                hold_o,
  input logic                rd_en_o,
  input logic [LINE_AW-1:0]  rd_line_o,
  input logic [CHUNK_AW-1:0] rd_chunk_o,
  input logic                tag_rd_en_o,
  input logic                wr_en_o,
  input logic [LINE_AW-1:0]  wr_line_o,
  input logic [CHUNK_AW-1:0] wr_chunk_o,
  input logic                tag_wr_en_o
);
  assert_rd_under_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o || wr_en_o) |-> hold_o);

  assert_hold_leads_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |=> rd_en_o);

  assert_hold_fall_after_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> ($past(wr_en_o) && !$past(rd_en_o)));

  assert_chunk_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o)) |->
      (rd_chunk_o == (($past(rd_chunk_o) == CHUNK_AW'(CHUNKS - 1)) ? '0
                      : CHUNK_AW'($past(rd_chunk_o) + CHUNK_AW'(1)))));

  assert_line_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o) && rd_chunk_o == '0 && CHUNKS > 1) |->
      (rd_line_o == LINE_AW'($past(rd_line_o) + LINE_AW'(1))));

  assert_wr_follows_rd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ($past(rd_en_o) && wr_line_o == $past(rd_line_o)
                 && wr_chunk_o == $past(rd_chunk_o)));

  assert_rd_gets_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> wr_en_o);

  assert_tag_rd_chunk0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_rd_en_o |-> (rd_en_o && rd_chunk_o == '0));

  assert_tag_wr_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_wr_en_o |-> ($past(tag_rd_en_o) && wr_en_o));

  assert_stopped_timer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && period_i == '0) |=> !hold_o);
endmodule

bind dyn_refresh_seq dyn_refresh_seq_chk #(
  .LINES   (LINES),
  .CHUNKS  (CHUNKS),
  .PERIOD_W(PERIOD_W),
  .LINE_AW (LINE_AW),
  .CHUNK_AW(CHUNK_AW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .period_i    (period_i),
  .hold_o      (hold_o),
  .rd_en_o     (rd_en_o),
  .rd_line_o   (rd_line_o),
  .rd_chunk_o  (rd_chunk_o),
  .tag_rd_en_o (tag_rd_en_o),
  .wr_en_o     (wr_en_o),
  .wr_line_o   (wr_line_o),
  .wr_chunk_o  (wr_chunk_o),
  .tag_wr_en_o (tag_wr_en_o)
);

// File: tb/dyn_refresh_seq_tb.sv
module dyn_refresh_seq_tb;
  localparam int LINES = 256, CHUNKS = 8, CHUNK_W = 64, TAG_W = 20, PERIOD_W = 16;
  localparam int LINE_AW = $clog2(LINES), CHUNK_AW = $clog2(CHUNKS);
  localparam int N = LINES * CHUNKS;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [PERIOD_W-1:0] per = '0;
  logic [CHUNK_W-1:0]  rd_data = '0;
  logic [TAG_W-1:0]    rd_tag = '0;
  logic hold_o, rd_en_o, tag_rd_en_o, wr_en_o, tag_wr_en_o;
  logic [LINE_AW-1:0]  rd_line_o, wr_line_o;
  logic [CHUNK_AW-1:0] rd_chunk_o, wr_chunk_o;
  logic [CHUNK_W-1:0]  wr_data_o;
  logic [TAG_W-1:0]    wr_tag_o;

  always #4 clk = ~clk;

  dyn_refresh_seq #(.LINES(LINES), .CHUNKS(CHUNKS), .CHUNK_W(CHUNK_W),
                    .TAG_W(TAG_W), .PERIOD_W(PERIOD_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .period_i(per), .rd_data_i(rd_data),
    .rd_tag_i(rd_tag), .hold_o(hold_o), .rd_en_o(rd_en_o),
    .rd_line_o(rd_line_o), .rd_chunk_o(rd_chunk_o), .tag_rd_en_o(tag_rd_en_o),
    .wr_en_o(wr_en_o), .wr_line_o(wr_line_o), .wr_chunk_o(wr_chunk_o),
    .wr_data_o(wr_data_o), .tag_wr_en_o(tag_wr_en_o), .wr_tag_o(wr_tag_o));

  int vectors = 0, errors = 0;
  bit chk_en = 1'b0, done = 1'b0;
  string blk_req = "R2";

  function automatic logic [CHUNK_W-1:0] dhash(int i);
    logic [31:0] a, b;
    a = 32'(i) * 32'h9E3779B1;
    b = ~(32'(i) * 32'h85EBCA6B);
    return {a, b};
  endfunction

  function automatic logic [TAG_W-1:0] thash(int i);
    logic [31:0] a;
    a = (32'(i) + 32'd7) * 32'h2545F491;
    return a[TAG_W-1:0];
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // array model: data returned one cycle after a read
  always @(posedge clk) begin
    rd_data <= rd_en_o ? dhash(int'(rd_line_o) * CHUNKS + int'(rd_chunk_o)) : '0;
    rd_tag  <= tag_rd_en_o ? thash(int'(rd_line_o)) : '0;
  end

  // reference model: ms = -1 idle, 0 arm, 1..N reads, N+1 final write
  int  ms = -1, mcnt = 0, marms = 0;
  bit  mpend = 1'b0;
  always @(posedge clk) begin
    bit exp_m, acc;
    if (!rst_ni) begin
      ms = -1; mcnt = 0; mpend = 1'b0;
    end else begin
      exp_m = (per != 0) && (mcnt >= int'(per) - 1);
      acc   = (ms == -1) || (ms == N + 1);
      mcnt  = (per == 0 || exp_m) ? 0 : mcnt + 1;
      if (acc) begin
        ms = (mpend || exp_m) ? 0 : -1;
        mpend = 1'b0;
      end else begin
        ms = ms + 1;
        mpend = mpend | exp_m;
      end
      if (ms == 0) marms++;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      bit erd, ewr;
      int idx;
      chk(hold_o == (ms >= 0), blk_req, "hold_o", 64'(hold_o), 64'(ms >= 0));
      erd = (ms >= 1) && (ms <= N);
      ewr = (ms >= 2) && (ms <= N + 1);
      chk(rd_en_o == erd, "R6", "rd_en_o", 64'(rd_en_o), 64'(erd));
      if (erd) begin
        idx = ms - 1;
        chk(rd_line_o == LINE_AW'(idx / CHUNKS), "R6", "rd_line_o", 64'(rd_line_o), 64'(idx / CHUNKS));
        chk(rd_chunk_o == CHUNK_AW'(idx % CHUNKS), "R6", "rd_chunk_o", 64'(rd_chunk_o), 64'(idx % CHUNKS));
        chk(tag_rd_en_o == (idx % CHUNKS == 0), "R8", "tag_rd_en_o", 64'(tag_rd_en_o), 64'(idx % CHUNKS == 0));
      end else
        chk(tag_rd_en_o == 1'b0, "R8", "tag_rd_en_o idle", 64'(tag_rd_en_o), 64'd0);
      chk(wr_en_o == ewr, "R7", "wr_en_o", 64'(wr_en_o), 64'(ewr));
      chk(tag_wr_en_o == (ewr && ((ms - 2) % CHUNKS == 0)), "R8", "tag_wr_en_o",
          64'(tag_wr_en_o), 64'(ewr && ((ms - 2) % CHUNKS == 0)));
      if (ewr) begin
        idx = ms - 2;
        chk(wr_line_o == LINE_AW'(idx / CHUNKS), "R7", "wr_line_o", 64'(wr_line_o), 64'(idx / CHUNKS));
        chk(wr_chunk_o == CHUNK_AW'(idx % CHUNKS), "R7", "wr_chunk_o", 64'(wr_chunk_o), 64'(idx % CHUNKS));
        chk(wr_data_o == dhash(idx), "R7", "wr_data_o", wr_data_o, dhash(idx));
        if (idx % CHUNKS == 0)
          chk(wr_tag_o == thash(idx / CHUNKS), "R8", "wr_tag_o", 64'(wr_tag_o), 64'(thash(idx / CHUNKS)));
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    int hi_cnt, lo_cnt, arm_dut, arm_ref;
    process::self().srandom(32'd1357);
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(!hold_o && !rd_en_o && !wr_en_o && !tag_rd_en_o && !tag_wr_en_o, "R1",
          "outputs in reset", {59'd0, hold_o, rd_en_o, wr_en_o, tag_rd_en_o, tag_wr_en_o}, 64'd0);
    end
    rst_ni = 1'b1;
    chk_en = 1'b1;
    @(negedge clk);
    chk(!hold_o && !rd_en_o && !wr_en_o, "R1", "first cycle after reset",
        {61'd0, hold_o, rd_en_o, wr_en_o}, 64'd0);

    // R3: stopped timer
    blk_req = "R3";
    hi_cnt = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (hold_o) hi_cnt++;
    end
    chk(hi_cnt == 0, "R3", "hold cycles with period 0", 64'(hi_cnt), 64'd0);

    // R2: spaced sweeps
    blk_req = "R2";
    per = 16'd4000;
    run(9000);
    chk(marms == 2, "R2", "sweeps started in 9000 cycles", 64'(marms), 64'd2);

    // R9/R10: period shorter than a sweep
    per = 16'd0;
    run(2200);
    blk_req = "R9";
    per = 16'd600;
    while (!hold_o) @(negedge clk);
    lo_cnt = 0; arm_dut = 0; arm_ref = marms;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (!hold_o) lo_cnt++;
      if (hold_o && !rd_en_o && !wr_en_o) arm_dut++;
    end
    chk(lo_cnt == 0, "R9", "gap cycles between queued sweeps", 64'(lo_cnt), 64'd0);
    chk(arm_dut == marms - arm_ref, "R10", "sweeps in window", 64'(arm_dut), 64'(marms - arm_ref));
    blk_req = "R10";
    per = 16'd0;
    run(4400);
    chk(!hold_o, "R10", "idle after queued sweep drains", 64'(hold_o), 64'd0);

    // R4: shortened period fires next edge
    blk_req = "R4";
    per = 16'd60000;
    run(100);
    chk(!hold_o, "R4", "idle before shrink", 64'(hold_o), 64'd0);
    per = 16'd10;
    @(negedge clk);
    chk(hold_o, "R4", "hold one edge after shrink", 64'(hold_o), 64'd1);
    per = 16'd0;
    run(2200);

    // random periods
    blk_req = "R2";
    for (int s = 0; s < 10; s++) begin
      per = ($urandom % 4 == 0) ? 16'd0 : 16'(150 + $urandom % 5000);
      run(500 + int'($urandom % 4000));
    end
    per = 16'd0;
    run(2200);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule